// File: doc/BRIEF.md
# Link Start-Up Sequence Controller

This block runs the bring-up of a serial radio-interface link. A seven-state machine moves the link through its phases: idle, layer-1 alignment, protocol agreement, control-and-management agreement, vendor and interface agreement, running, and a passive state entered from running. Four completion flags gate the forward steps. The flags and the current phase are held together in one 32-bit control/status word.

The flags can come from two places, chosen at elaboration. In software mode a register write port sets and clears them, and for the protocol flag and the control-and-management flag the block can complete the flag itself when configuration auto bits are set. In pin mode four dedicated inputs load the flags on every clock, and software writes have no effect on them. The state code is a Gray-style 3-bit value. A monitor sees a single bit flip on each forward step.

Top module: `lsu_startup_ctrl`

## Requirements
- R1: After synchronous reset the phase is idle (code 000), all four flags are 0, and the read data output is 0.
- R2: The phase codes are idle 000, layer-1 alignment 001, protocol 011, control/management 010, vendor/interface 110, running 111, passive 101. Code 100 never appears. The code is reported in bits [10:8] of the status word, both on the state output and in read data.
- R3: From idle the machine moves to layer-1 alignment when start is high. When stop is high, the next phase is idle from any phase, and stop has priority over every other input.
- R4: Layer-1 alignment moves to protocol only when the layer-1-locked input is high and flag bit 0 (rate agreed) is set.
- R5: Protocol moves on to control/management only when flag bit 1 is set. Control/management moves on to vendor/interface only when flag bit 2 is set. Vendor/interface moves on to running only when flag bit 3 is set.
- R6: When layer-1-locked is low in any phase from protocol through passive, the next phase is layer-1 alignment.
- R7: Running moves to passive while the passive request input is high. Passive returns to running when that input is low.
- R8: A write to the status word address in software mode loads flags [3:0] from write data [3:0]. Write data bits [31:4] are ignored. Read data bits [7:4] and [31:11] always read 0.
- R9: In software mode, during the first cycle in the protocol phase, if the protocol auto bit is high, flag bit 1 is clear and no write occurs, then flag bit 1 is set at the next edge.
- R10: In software mode, during the first cycle in the control/management phase, if either control/management auto bit (slow or fast) is high, flag bit 2 is clear and no write occurs, then flag bit 2 is set at the next edge.
- R11: In pin mode, the flags take the value of the four pin inputs at every edge, software writes leave them unchanged, and no auto-completion takes place.
- R12: Writes to any other address change nothing. A read of any other address returns 0. Read data is registered: it shows the word from the cycle in which the read was requested.
- R13: A phase change happens at the first clock edge at which its gating condition is seen on the registered flags and inputs. A flag written at an edge gates the phase only from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Leave idle |
| stop_i | input | 1 | Return to idle from any phase |
| l1_lock_i | input | 1 | Layer-1 alignment achieved |
| passive_req_i | input | 1 | Request passive operation while running |
| proto_auto_i | input | 1 | Auto-complete the protocol flag |
| cm_slow_auto_i | input | 1 | Auto-complete the control/management flag (slow channel) |
| cm_fast_auto_i | input | 1 | Auto-complete the control/management flag (fast channel) |
| done_pins_i | input | 4 | Completion flags for pin mode |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data |
| state_o | output | 3 | Current phase code |

## Verification
The hardest cases to reach are auto-completion, which happens only in the first cycle of a phase that lies several gated steps from idle, and the return to running from passive, which needs every earlier flag set and layer-1 lock held. A directed walk sets the rate flag, raises the auto bits and steps from idle through both auto-completed phases, edge by edge. A long pseudo-random sweep then biases lock high, stop rare and writes frequent, so that every phase is visited many times, and a bench model built from the requirements predicts each cycle for a software-mode and a pin-mode instance.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int FLAG_N  = 4;
    localparam int CSR_W   = 32;
    localparam int FL_RATE = 0;
    localparam int FL_PROT = 1;
    localparam int FL_CM   = 2;
    localparam int FL_VEND = 3;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'b000,
        ST_L1      = 3'b001,
        ST_PROTO   = 3'b011,
        ST_CM      = 3'b010,
        ST_NEGO    = 3'b110,
        ST_RUN     = 3'b111,
        ST_PASSIVE = 3'b101
    } lsu_state_e;

    typedef struct packed {
        logic [20:0]       zero_hi;
        lsu_state_e        phase;
        logic [3:0]        zero_mid;
        logic [FLAG_N-1:0] flags;
    } lsu_csr_t;

    function automatic lsu_csr_t pack_csr(lsu_state_e st, logic [FLAG_N-1:0] fl);
        lsu_csr_t w;
        w.zero_hi  = '0;
        w.phase    = st;
        w.zero_mid = '0;
        w.flags    = fl;
        return w;
    endfunction

    // phases that rely on layer-1 lock being held
    function automatic logic needs_lock(lsu_state_e st);
        return (st == ST_PROTO) || (st == ST_CM) || (st == ST_NEGO) ||
               (st == ST_RUN) || (st == ST_PASSIVE);
    endfunction

endpackage

// File: rtl/lsu_fsm.sv
module lsu_fsm
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              l1_ok,
    input  logic              passive,
    input  logic [FLAG_N-1:0] flags,
    output lsu_state_e        state,
    output logic              entered
);

    lsu_state_e state_q, prev_q, state_d;

    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = ST_IDLE;
        end else if (needs_lock(state_q) && !l1_ok) begin
            state_d = ST_L1;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start) state_d = ST_L1;
                ST_L1:      if (l1_ok && flags[FL_RATE]) state_d = ST_PROTO;
                ST_PROTO:   if (flags[FL_PROT]) state_d = ST_CM;
                ST_CM:      if (flags[FL_CM]) state_d = ST_NEGO;
                ST_NEGO:    if (flags[FL_VEND]) state_d = ST_RUN;
                ST_RUN:     if (passive) state_d = ST_PASSIVE;
                ST_PASSIVE: if (!passive) state_d = ST_RUN;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            prev_q  <= ST_IDLE;
        end else begin
            state_q <= state_d;
            prev_q  <= state_q;
        end
    end

    assign state   = state_q;
    assign entered = (state_q != prev_q);

    // R3: stop forces idle on the next edge
    p_stop_idle_r3: assert property (@(posedge clk) disable iff (rst)
        stop |=> (state == ST_IDLE));

    // R6: lock loss in a locked phase falls back to alignment
    p_lock_loss_r6: assert property (@(posedge clk) disable iff (rst)
        (!stop && !l1_ok && needs_lock(state)) |=> (state == ST_L1));

    // R5: protocol phase holds while its flag is clear
    p_proto_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROTO && !stop && l1_ok && !flags[FL_PROT]) |=> (state == ST_PROTO));

    // R7: passive leaves only to running, alignment or idle
    p_passive_ret_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASSIVE && !stop && l1_ok && !passive) |=> (state == ST_RUN));

    // R2: the unused code never shows up
    p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        state != 3'b100);

endmodule

// File: rtl/lsu_flags.sv
module lsu_flags
    import lsu_pkg::*;
#(
    parameter bit PIN_DRIVEN = 1'b0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [FLAG_N-1:0] sw_data,
    input  logic [FLAG_N-1:0] pin_done,
    input  lsu_state_e        state,
    input  logic              entered,
    input  logic              proto_auto,
    input  logic              cm_auto,
    output logic [FLAG_N-1:0] flags
);

    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] auto_req;

    always_comb begin
        auto_req          = '0;
        auto_req[FL_PROT] = entered && (state == ST_PROTO) && proto_auto;
        auto_req[FL_CM]   = entered && (state == ST_CM) && cm_auto;
    end

    generate
        if (PIN_DRIVEN) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst) flags_q <= '0;
                else     flags_q <= pin_done;
            end

            // R11: pins load the flags every edge
            p_pin_follow_r11: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (flags == $past(pin_done)));
        end else begin : g_sw
            for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
                always_ff @(posedge clk) begin
                    if (rst)             flags_q[i] <= 1'b0;
                    else if (sw_we)      flags_q[i] <= sw_data[i];
                    else if (auto_req[i]) flags_q[i] <= 1'b1;
                end
            end

            // R8: a write loads the flags
            p_sw_load_r8: assert property (@(posedge clk) disable iff (rst)
                sw_we |=> (flags == $past(sw_data)));

            // R9: protocol auto-completion on first cycle in phase
            p_auto_proto_r9: assert property (@(posedge clk) disable iff (rst)
                (state == ST_PROTO && entered && proto_auto && !sw_we) |=> flags[FL_PROT]);

            // R10: control/management auto-completion
            p_auto_cm_r10: assert property (@(posedge clk) disable iff (rst)
                (state == ST_CM && entered && cm_auto && !sw_we) |=> flags[FL_CM]);
        end
    endgenerate

    assign flags = flags_q;

endmodule

// File: rtl/lsu_startup_ctrl.sv
module lsu_startup_ctrl
    import lsu_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int CSR_ADDR   = 0,
    parameter bit PIN_DRIVEN = 1'b0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              l1_lock_i,
    input  logic              passive_req_i,
    input  logic              proto_auto_i,
    input  logic              cm_slow_auto_i,
    input  logic              cm_fast_auto_i,
    input  logic [FLAG_N-1:0] done_pins_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CSR_W-1:0]  wdata_i,
    output logic [CSR_W-1:0]  rdata_o,
    output logic [2:0]        state_o
);

    localparam logic [ADDR_W-1:0] CSR_SEL = ADDR_W'(CSR_ADDR);

    logic              hit;
    logic              sw_we;
    logic              entered;
    logic [FLAG_N-1:0] flags;
    lsu_state_e        state;
    lsu_csr_t          csr_word;
    logic [CSR_W-1:0]  rdata_q;

    assign hit   = (addr_i == CSR_SEL);
    assign sw_we = wr_en_i && hit;

    lsu_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .stop    (stop_i),
        .l1_ok   (l1_lock_i),
        .passive (passive_req_i),
        .flags   (flags),
        .state   (state),
        .entered (entered)
    );

    lsu_flags #(.PIN_DRIVEN(PIN_DRIVEN)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .sw_we      (sw_we),
        .sw_data    (wdata_i[FLAG_N-1:0]),
        .pin_done   (done_pins_i),
        .state      (state),
        .entered    (entered),
        .proto_auto (proto_auto_i),
        .cm_auto    (cm_slow_auto_i || cm_fast_auto_i),
        .flags      (flags)
    );

    assign csr_word = pack_csr(state, flags);

    always_ff @(posedge clk) begin
        if (rst)                 rdata_q <= '0;
        else if (rd_en_i && hit) rdata_q <= csr_word;
        else                     rdata_q <= '0;
    end

    assign rdata_o = rdata_q;
    assign state_o = state;

    // R12: reads elsewhere return zero
    p_other_addr_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !hit) |=> (rdata_o == '0));

    // R8: reserved read bits stay clear
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rdata_o[7:4] == 4'b0) && (rdata_o[31:11] == 21'b0));

    // R2: read data carries the phase seen on the state output
    p_phase_field_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && hit) |=> (rdata_o[10:8] == $past(state_o)));

endmodule

// File: tb/sim_lsu_startup_ctrl.sv
module sim_lsu_startup_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, stop, l1, passive, pauto, cslow, cfast;
    logic [3:0]  pins;
    logic        wr, rd;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata0, rdata1;
    logic [2:0]  st0, st1;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;
    int visits [8];

    always #5 clk = ~clk;

    lsu_startup_ctrl #(.ADDR_W(4), .CSR_ADDR(0), .PIN_DRIVEN(1'b0)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .l1_lock_i(l1),
        .passive_req_i(passive), .proto_auto_i(pauto), .cm_slow_auto_i(cslow),
        .cm_fast_auto_i(cfast), .done_pins_i(pins), .wr_en_i(wr), .rd_en_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0), .state_o(st0));

    lsu_startup_ctrl #(.ADDR_W(4), .CSR_ADDR(0), .PIN_DRIVEN(1'b1)) u1 (
        .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .l1_lock_i(l1),
        .passive_req_i(passive), .proto_auto_i(pauto), .cm_slow_auto_i(cslow),
        .cm_fast_auto_i(cfast), .done_pins_i(pins), .wr_en_i(wr), .rd_en_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .state_o(st1));

    // reference model from the requirements
    logic [2:0]  m_st0, m_pv0, m_st1;
    logic [3:0]  m_f0, m_f1;
    logic [31:0] m_rd0, m_rd1;

    function automatic logic locked_phase(logic [2:0] s);
        return (s == 3'b011) || (s == 3'b010) || (s == 3'b110) ||
               (s == 3'b111) || (s == 3'b101);
    endfunction

    function automatic logic [2:0] nxt(logic [2:0] s, logic [3:0] f);
        if (stop) return 3'b000;
        if (locked_phase(s) && !l1) return 3'b001;
        case (s)
            3'b000: return start ? 3'b001 : s;
            3'b001: return (l1 && f[0]) ? 3'b011 : s;
            3'b011: return f[1] ? 3'b010 : s;
            3'b010: return f[2] ? 3'b110 : s;
            3'b110: return f[3] ? 3'b111 : s;
            3'b111: return passive ? 3'b101 : s;
            3'b101: return passive ? s : 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st0 <= 3'b000; m_pv0 <= 3'b000; m_st1 <= 3'b000;
            m_f0 <= 4'h0; m_f1 <= 4'h0; m_rd0 <= '0; m_rd1 <= '0;
        end else begin
            logic [3:0] nf;
            nf = m_f0;
            if (wr && addr == 4'd0) nf = wdata[3:0];
            else begin
                if (m_st0 != m_pv0 && m_st0 == 3'b011 && pauto) nf[1] = 1'b1;
                if (m_st0 != m_pv0 && m_st0 == 3'b010 && (cslow || cfast)) nf[2] = 1'b1;
            end
            m_f0  <= nf;
            m_st0 <= nxt(m_st0, m_f0);
            m_pv0 <= m_st0;
            m_f1  <= pins;
            m_st1 <= nxt(m_st1, m_f1);
            m_rd0 <= (rd && addr == 4'd0) ? {21'b0, m_st0, 4'b0, m_f0} : '0;
            m_rd1 <= (rd && addr == 4'd0) ? {21'b0, m_st1, 4'b0, m_f1} : '0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // continuous comparison against the model
    always @(negedge clk) begin
        if (chk_on && !rst) begin
            check(st0 == m_st0, "R3 R4 R5 R6 R7 R13 phase sw", {29'b0, st0}, {29'b0, m_st0});
            check(st1 == m_st1, "R11 phase pin", {29'b0, st1}, {29'b0, m_st1});
            check(rdata0 == m_rd0, "R8 R9 R10 R12 read sw", rdata0, m_rd0);
            check(rdata1 == m_rd1, "R11 R12 read pin", rdata1, m_rd1);
            visits[st0]++;
        end
    end

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_csr(input logic [3:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d; step(); wr = 1'b0; addr = 4'd0;
    endtask

    task automatic rd_csr(input logic [3:0] a);
        rd = 1'b1; addr = a; step(); rd = 1'b0; addr = 4'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; start = 0; stop = 0; l1 = 0; passive = 0;
        pauto = 0; cslow = 0; cfast = 0; pins = 4'h0;
        wr = 0; rd = 0; addr = 4'd0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;

        // R1: reset values
        check(st0 == 3'b000, "R1 reset phase", {29'b0, st0}, 32'h0);
        check(rdata0 == 32'h0, "R1 reset rdata", rdata0, 32'h0);
        rd_csr(4'd0);
        check(rdata0 == 32'h0, "R1 reset word", rdata0, 32'h0);

        // R8: only bits [3:0] are writable
        wr_csr(4'd0, 32'hFFFF_FFF0);
        rd_csr(4'd0);
        check(rdata0 == 32'h0, "R8 upper write ignored", rdata0, 32'h0);
        wr_csr(4'd0, 32'h0000_0005);
        rd_csr(4'd0);
        check(rdata0 == 32'h5, "R8 flag load", rdata0, 32'h5);

        // R12: other address
        wr_csr(4'd3, 32'hF);
        rd_csr(4'd0);
        check(rdata0 == 32'h5, "R12 foreign write ignored", rdata0, 32'h5);
        rd_csr(4'd3);
        check(rdata0 == 32'h0, "R12 foreign read zero", rdata0, 32'h0);

        // R11: pin mode follows pins, ignores writes
        pins = 4'hA;
        step();
        wr_csr(4'd0, 32'h5);
        rd_csr(4'd0);
        check(rdata1 == 32'hA, "R11 pins load flags", rdata1, 32'hA);
        pins = 4'h0;

        // directed walk through auto-completion, R9 R10 R13
        wr_csr(4'd0, 32'h1);
        pauto = 1; cslow = 1; l1 = 1; start = 1;
        step();
        check(st0 == 3'b001, "R3 idle to alignment", {29'b0, st0}, 32'h1);
        step();
        check(st0 == 3'b011, "R4 alignment to protocol", {29'b0, st0}, 32'h3);
        step();
        check(st0 == 3'b011, "R13 auto flag not yet seen", {29'b0, st0}, 32'h3);
        step();
        check(st0 == 3'b010, "R9 protocol auto completed", {29'b0, st0}, 32'h2);
        step(); step();
        check(st0 == 3'b110, "R10 cm auto completed", {29'b0, st0}, 32'h6);
        step(); step();
        rd_csr(4'd0);
        check(rdata0 == 32'h607, "R2 R9 R10 word in vendor phase", rdata0, 32'h607);
        wr_csr(4'd0, 32'hF);
        check(st0 == 3'b110, "R13 written flag gates next edge", {29'b0, st0}, 32'h6);
        step();
        check(st0 == 3'b111, "R5 vendor to running", {29'b0, st0}, 32'h7);
        passive = 1; step();
        check(st0 == 3'b101, "R7 running to passive", {29'b0, st0}, 32'h5);
        passive = 0; step();
        check(st0 == 3'b111, "R7 passive to running", {29'b0, st0}, 32'h7);
        l1 = 0; step();
        check(st0 == 3'b001, "R6 lock loss", {29'b0, st0}, 32'h1);
        stop = 1; step();
        check(st0 == 3'b000, "R3 stop to idle", {29'b0, st0}, 32'h0);
        stop = 0; pauto = 0; cslow = 0; start = 0;

        // pseudo-random sweep checked every cycle against the model
        for (int i = 0; i < 5000; i++) begin
            r = 32'h1234_5678 ^ (i * 32'h9E37_79B9);
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            stop    = (r[5:0] == 6'd0);
            l1      = (r[10:6] != 5'd0);
            start   = r[11];
            passive = r[12] & r[13];
            pauto   = r[14];
            cslow   = r[15] & r[16];
            cfast   = r[17] & r[18];
            pins    = r[22:19];
            wr      = (r[24:23] == 2'b00);
            rd      = r[25];
            addr    = r[28:26] == 3'd7 ? 4'd2 : 4'd0;
            wdata   = {r[31:29], r[28:0] ^ {r[2:0], r[31:6]}};
            step();
        end
        wr = 0; rd = 0; stop = 0;

        // R2: every legal phase was reached, code 100 never
        check(visits[0] > 0, "R2 idle visited", visits[0], 1);
        check(visits[1] > 0, "R2 alignment visited", visits[1], 1);
        check(visits[3] > 0, "R2 protocol visited", visits[3], 1);
        check(visits[2] > 0, "R2 cm visited", visits[2], 1);
        check(visits[6] > 0, "R2 vendor visited", visits[6], 1);
        check(visits[7] > 0, "R2 running visited", visits[7], 1);
        check(visits[5] > 0, "R2 passive visited", visits[5], 1);
        check(visits[4] == 0, "R2 code 100 absent", visits[4], 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule